// File: doc/BRIEF.md
# Host Shared-Memory Access Port

This block is the host-facing window into a byte-wide memory that a host CPU shares with an I/O coprocessor. The host sees four byte registers on a simple byte bus. Two of them hold a 16-bit memory pointer, loaded one byte at a time. One is a data port that reads or writes the memory byte the pointer selects. The last is a status/control byte. When autoincrement is on, each data access moves the pointer forward by one, so a buffer can be streamed through the single data port.

The status/control byte carries three things. The first is the coprocessor run bit, which holds the coprocessor in reset while it is low. The second is an interrupt request from the host toward the coprocessor. The third is a pair of sticky interrupt flags that the coprocessor raises toward the host. The host clears these flags by writing ones to them.

The coprocessor reaches the same memory through its own port on the memory. Only the low `ADDR_W` bits of the pointer index the memory, so the upper pointer bits alias.

Top module: `shmem_host_port`

## Requirements
- R1: After reset the status/control byte reads 0x00, and `cp_run`, `cp_irq`, `host_irq` and the pointer are all 0.
- R2: A write to offset 0 loads the pointer high byte, and a write to offset 2 loads the pointer low byte. Reads of the same offsets return those bytes.
- R3: A write to offset 8 stores the byte at memory location pointer[ADDR_W-1:0], where the coprocessor port can read it. A read of offset 8 returns the byte at that location, including bytes the coprocessor wrote. Host read data appears on `hb_rdata` one clock after the read access and is held until the next read.
- R4: With status bit 1 (autoincrement) set, every data read or write advances the 16-bit pointer by one. With bit 1 clear, the pointer is left unchanged.
- R5: Autoincrement from 0xFFFF gives 0x0000, and both pointer bytes read back the new value.
- R6: Status bit 2 is the run bit and drives `cp_run`. Writing it as 0 drives `cp_run` low, which holds the coprocessor in reset.
- R7: Status bit 3 drives `cp_irq`, the request toward the coprocessor.
- R8: A pulse on `cp_flag_set[0]` or `cp_flag_set[1]` sets status bit 4 or bit 5 respectively. The flag stays set until it is cleared. `host_irq` is the OR of the two flags.
- R9: Writing 1 to status bit 4 or 5 clears that flag, and writing 0 leaves it as it is. If a set pulse and a clearing write land in the same cycle, the flag ends up set.
- R10: Status bits 0, 6 and 7 always read 0, and writes to them have no effect. Writes to offsets other than 0, 2, 4 and 8 change nothing, and reads of those offsets return 0.
- R11: When the host and the coprocessor write the same memory location in the same cycle, the host byte is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_sel | input | 1 | Host bus access strobe, one cycle per access |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | OFS_W | Register byte offset |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data, registered |
| cp_we | input | 1 | Coprocessor memory write enable |
| cp_addr | input | ADDR_W | Coprocessor memory address |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rdata | output | 8 | Coprocessor read data, one cycle after address |
| cp_flag_set | input | 2 | Coprocessor pulses that set the host interrupt flags |
| cp_run | output | 1 | Coprocessor run (low = held in reset) |
| cp_irq | output | 1 | Interrupt request toward the coprocessor |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
A wrong pointer state does not show up at once. It appears on the next data access as a byte landing at, or coming from, the wrong memory location, and it is visible directly on the next pointer-byte read. A flag that fails to stick, or fails to clear, shows on `host_irq` one clock after the event that caused it. A wrong control bit reaches `cp_run` or `cp_irq` one clock after the status write. Each directed scenario therefore reads back through both the host data port and the coprocessor port on the cycle right after the access under test.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

  localparam int PTR_W   = 16;
  localparam int BIT_AIN = 1;
  localparam int BIT_RUN = 2;
  localparam int BIT_IRQ = 3;
  localparam int BIT_F0  = 4;
  localparam int BIT_F1  = 5;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PHI,
    REG_PLO,
    REG_CTL,
    REG_DATA
  } reg_sel_e;

  // Only even offsets map to registers; bit 0 of the offset is part of the decode.
  function automatic reg_sel_e decode_ofs(input logic [3:0] ofs);
    case (ofs)
      4'd0:    return REG_PHI;
      4'd2:    return REG_PLO;
      4'd4:    return REG_CTL;
      4'd8:    return REG_DATA;
      default: return REG_NONE;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [7:0] pack_status(input logic ain, input logic run,
                                             input logic irq, input logic [1:0] flg);
    logic [7:0] s;
    s          = 8'h00;
    s[BIT_AIN] = ain;
    s[BIT_RUN] = run;
    s[BIT_IRQ] = irq;
    s[BIT_F0]  = flg[0];
    s[BIT_F1]  = flg[1];
    return s;
  endfunction

endpackage

// File: rtl/shmem_ptr_reg.sv
module shmem_ptr_reg
  import shmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wdata,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (wr_hi) ptr <= {wdata, ptr[7:0]};
    else if (wr_lo) ptr <= {ptr[PTR_W-1:8], wdata};
    else if (step)  ptr <= ptr_next(ptr);
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !wr_lo && !step) |=> $stable(ptr)); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_hi && !wr_lo && ptr == 16'hFFFF) |=> (ptr == 16'h0000)); // R5
  AST_PTR_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (ptr[15:8] == $past(wdata))); // R2

endmodule

// File: rtl/shmem_ctrl_reg.sv
module shmem_ctrl_reg
  import shmem_pkg::*;
#(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             ain_d,
  input  logic             run_d,
  input  logic             irq_d,
  input  logic [NFLAG-1:0] clr_d,
  input  logic [NFLAG-1:0] set_in,
  output logic             ain,
  output logic             run,
  output logic             irq,
  output logic [NFLAG-1:0] flags
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ain <= 1'b0;
      run <= 1'b0;
      irq <= 1'b0;
    end else if (wr) begin
      ain <= ain_d;
      run <= run_d;
      irq <= irq_d;
    end
  end

  AST_RUN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !run_d) |=> !run); // R6

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q & ~(wr & clr_d[i])) | set_in[i];
    end
    assign flags[i] = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_in[i] |=> flag_q); // R8
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr && clr_d[i])) |=> flag_q); // R9
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && clr_d[i] && !set_in[i]) |=> !flag_q); // R9
  end

endmodule

// File: rtl/shmem_dpram.sv
module shmem_dpram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              c_we,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // The host write is issued last, so it takes the location on a collision.
  always_ff @(posedge clk) begin
    if (c_we) mem[c_addr] <= c_wdata;
    if (h_we) mem[h_addr] <= h_wdata;
  end

  always_ff @(posedge clk) c_rdata <= mem[c_addr];

  assign h_rdata = mem[h_addr];

endmodule

// File: rtl/shmem_host_port.sv
module shmem_host_port
  import shmem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_sel,
  input  logic              hb_wr,
  input  logic [OFS_W-1:0]  hb_addr,
  input  logic [7:0]        hb_wdata,
  output logic [7:0]        hb_rdata,
  input  logic              cp_we,
  input  logic [ADDR_W-1:0] cp_addr,
  input  logic [7:0]        cp_wdata,
  output logic [7:0]        cp_rdata,
  input  logic [1:0]        cp_flag_set,
  output logic              cp_run,
  output logic              cp_irq,
  output logic              host_irq
);

  localparam int NFLAG = 2;

  reg_sel_e         sel;
  logic             wr_acc, rd_acc;
  logic             ev_phi_wr, ev_plo_wr, ev_ctl_wr, ev_dat_wr, ev_dat_rd, ev_step;
  logic [PTR_W-1:0] ptr;
  logic             ain;
  logic [NFLAG-1:0] flags;
  logic [7:0]       ram_byte;
  logic [7:0]       rd_mux;

  assign sel    = hb_sel ? decode_ofs(4'(hb_addr)) : REG_NONE;
  assign wr_acc = hb_sel & hb_wr;
  assign rd_acc = hb_sel & ~hb_wr;

  assign ev_phi_wr = wr_acc && sel == REG_PHI;
  assign ev_plo_wr = wr_acc && sel == REG_PLO;
  assign ev_ctl_wr = wr_acc && sel == REG_CTL;
  assign ev_dat_wr = wr_acc && sel == REG_DATA;
  assign ev_dat_rd = rd_acc && sel == REG_DATA;
  assign ev_step   = (ev_dat_wr | ev_dat_rd) & ain;

  shmem_ptr_reg u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_hi (ev_phi_wr),
    .wr_lo (ev_plo_wr),
    .wdata (hb_wdata),
    .step  (ev_step),
    .ptr   (ptr)
  );

  shmem_ctrl_reg #(.NFLAG(NFLAG)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ev_ctl_wr),
    .ain_d  (hb_wdata[BIT_AIN]),
    .run_d  (hb_wdata[BIT_RUN]),
    .irq_d  (hb_wdata[BIT_IRQ]),
    .clr_d  ({hb_wdata[BIT_F1], hb_wdata[BIT_F0]}),
    .set_in (cp_flag_set),
    .ain    (ain),
    .run    (cp_run),
    .irq    (cp_irq),
    .flags  (flags)
  );

  shmem_dpram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
    .clk     (clk),
    .h_we    (ev_dat_wr),
    .h_addr  (ptr[ADDR_W-1:0]),
    .h_wdata (hb_wdata),
    .h_rdata (ram_byte),
    .c_we    (cp_we),
    .c_addr  (cp_addr),
    .c_wdata (cp_wdata),
    .c_rdata (cp_rdata)
  );

  always_comb begin
    case (sel)
      REG_PHI:  rd_mux = ptr[15:8];
      REG_PLO:  rd_mux = ptr[7:0];
      REG_CTL:  rd_mux = pack_status(ain, cp_run, cp_irq, flags);
      REG_DATA: rd_mux = ram_byte;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hb_rdata <= 8'h00;
    else if (rd_acc) hb_rdata <= rd_mux;
  end

  assign host_irq = |flags;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel == REG_CTL) |=> (hb_rdata[7:6] == 2'b00 && !hb_rdata[0])); // R10
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel == REG_NONE) |=> (hb_rdata == 8'h00)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(hb_rdata)); // R3
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ctl_wr) |=> (cp_irq == $past(hb_wdata[BIT_IRQ]))); // R7

endmodule

// File: tb/tb_shmem_host_port.sv
module tb_shmem_host_port;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hb_sel, hb_wr;
  logic [3:0]    hb_addr;
  logic [7:0]    hb_wdata, hb_rdata;
  logic          cp_we;
  logic [AW-1:0] cp_addr;
  logic [7:0]    cp_wdata, cp_rdata;
  logic [1:0]    cp_flag_set;
  logic          cp_run, cp_irq, host_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  shmem_host_port #(.ADDR_W(AW), .OFS_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .cp_we(cp_we), .cp_addr(cp_addr),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_flag_set(cp_flag_set),
    .cp_run(cp_run), .cp_irq(cp_irq), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] ofs, input logic [7:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = ofs; hb_wdata = d;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] ofs, output logic [7:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b0; hb_addr = ofs;
    @(negedge clk);
    hb_sel = 1'b0;
    d = hb_rdata;
  endtask

  task automatic cp_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cp_we = 1'b1; cp_addr = a; cp_wdata = d;
    @(negedge clk);
    cp_we = 1'b0;
  endtask

  task automatic cp_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    cp_addr = a;
    @(negedge clk);
    d = cp_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    bus_wr(4'd0, p[15:8]);
    bus_wr(4'd2, p[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(4'd4, d);  chk("R1 status", d, 8'h00);
    chk("R1 cp_run", cp_run, 0);
    chk("R1 cp_irq", cp_irq, 0);
    chk("R1 host_irq", host_irq, 0);
    bus_rd(4'd0, d);  chk("R1 ptr hi", d, 8'h00);
  endtask

  task automatic t_ptr;
    logic [7:0] d;
    set_ptr(16'h1234);
    bus_rd(4'd0, d); chk("R2 hi", d, 8'h12);
    bus_rd(4'd2, d); chk("R2 lo", d, 8'h34);
  endtask

  task automatic t_data;
    logic [7:0] d;
    bus_wr(4'd4, 8'h00);
    set_ptr(16'h1234);
    bus_wr(4'd8, 8'hA5);
    cp_read(10'h234, d); chk("R3 host->cp", d, 8'hA5);
    bus_rd(4'd2, d);     chk("R4 no step lo", d, 8'h34);
    cp_write(10'h235, 8'h5A);
    bus_wr(4'd2, 8'h35);
    bus_rd(4'd8, d);     chk("R3 cp->host", d, 8'h5A);
    bus_rd(4'd2, d);     chk("R3 rdata held, lo", d, 8'h35);
  endtask

  task automatic t_autoinc;
    logic [7:0] d;
    bus_wr(4'd4, 8'h02);
    set_ptr(16'h0010);
    for (int i = 0; i < 3; i++) bus_wr(4'd8, 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 3; i++) begin
      cp_read(10'(16 + i), d); chk("R4 stream write", d, 8'(8'h11 * (i + 1)));
    end
    bus_rd(4'd2, d); chk("R4 lo after writes", d, 8'h13);
    set_ptr(16'h0010);
    for (int i = 0; i < 3; i++) begin
      bus_rd(4'd8, d); chk("R4 stream read", d, 8'(8'h11 * (i + 1)));
    end
    bus_rd(4'd2, d); chk("R4 lo after reads", d, 8'h13);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    set_ptr(16'hFFFF);
    bus_wr(4'd8, 8'h77);
    bus_rd(4'd0, d); chk("R5 hi", d, 8'h00);
    bus_rd(4'd2, d); chk("R5 lo", d, 8'h00);
    cp_read(10'h3FF, d); chk("R3 alias top", d, 8'h77);
  endtask

  task automatic t_run_irq;
    logic [7:0] d;
    bus_wr(4'd4, 8'h04);
    chk("R6 run high", cp_run, 1); chk("R7 irq low", cp_irq, 0);
    bus_wr(4'd4, 8'h0C);
    chk("R7 irq high", cp_irq, 1);
    bus_rd(4'd4, d); chk("R6 R7 status", d, 8'h0C);
    bus_wr(4'd4, 8'h08);
    chk("R6 run low", cp_run, 0); chk("R7 irq kept", cp_irq, 1);
    bus_wr(4'd4, 8'h00);
  endtask

  task automatic t_flags;
    logic [7:0] d;
    @(negedge clk); cp_flag_set = 2'b01;
    @(negedge clk); cp_flag_set = 2'b00;
    chk("R8 host_irq f0", host_irq, 1);
    bus_rd(4'd4, d); chk("R8 status f0", d, 8'h10);
    bus_wr(4'd4, 8'h00);
    chk("R9 write0 keeps", host_irq, 1);
    bus_wr(4'd4, 8'h10);
    chk("R9 clear f0", host_irq, 0);
    @(negedge clk); cp_flag_set = 2'b10;
    @(negedge clk); cp_flag_set = 2'b00;
    bus_rd(4'd4, d); chk("R8 status f1", d, 8'h20);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = 4'd4; hb_wdata = 8'h20; cp_flag_set = 2'b10;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0; cp_flag_set = 2'b00;
    chk("R9 set wins", host_irq, 1);
    bus_wr(4'd4, 8'h30);
    chk("R9 both cleared", host_irq, 0);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    bus_wr(4'd4, 8'hC1);
    bus_rd(4'd4, d); chk("R10 rsv bits", d, 8'h00);
    set_ptr(16'h0155);
    bus_wr(4'd6, 8'hFF);
    bus_wr(4'd1, 8'hFF);
    bus_wr(4'd3, 8'hEE);
    bus_rd(4'd0, d); chk("R10 hi intact", d, 8'h01);
    bus_rd(4'd2, d); chk("R10 lo intact", d, 8'h55);
    bus_rd(4'd4, d); chk("R10 status intact", d, 8'h00);
    bus_rd(4'd6, d); chk("R10 unmapped 6", d, 8'h00);
    bus_rd(4'd1, d); chk("R10 unmapped 1", d, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    set_ptr(16'h0050);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = 4'd8; hb_wdata = 8'hAA;
    cp_we = 1'b1; cp_addr = 10'h050; cp_wdata = 8'hBB;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0; cp_we = 1'b0;
    cp_read(10'h050, d); chk("R11 host wins", d, 8'hAA);
  endtask

  initial begin
    rst_n = 1'b0; hb_sel = 1'b0; hb_wr = 1'b0; hb_addr = '0; hb_wdata = '0;
    cp_we = 1'b0; cp_addr = '0; cp_wdata = '0; cp_flag_set = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr();
    t_data();
    t_autoinc();
    t_wrap();
    t_run_irq();
    t_flags();
    t_reserved();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule